// File: doc/BRIEF.md
# Biphase-Mark Serial Byte Encoder

This block turns bytes into a self-clocking serial line. An upstream source offers a byte with `data_ready`. While `busy_out` is low the byte is captured on the next clock edge, and `busy_out` rises one cycle later. The sender then drops `data_ready`. The byte is framed as an asynchronous character: a 0 start bit, eight data bits with the least significant bit first, and a 1 stop bit. The character is then driven onto `line_out` in biphase-mark form.

Every bit boundary inverts the line. A 1 holds one level for the whole bit period. A 0 adds a second inversion partway through, so it appears as two short pulses. Between characters the line carries continuous 1 bits, which means it inverts once per bit period. With the defaults, a 50 MHz clock and 666 cycles per bit give about 75 kbit/s, with a first half of 333 cycles and a second half of 333 cycles.

A plain NRZ copy of each character appears on `nrz_out` for a standard UART receiver to monitor. A bit-period timer runs all the time. A new character begins at the first bit boundary after its byte is accepted.

Top module: `bpe_encoder`

## Requirements
- R1: An active-low asynchronous reset sets `line_out` to 1, `nrz_out` to 1 and `busy_out` to 0.
- R2: Every bit period lasts exactly BIT_CYCLES clocks, and `line_out` inverts at every bit boundary. A 1 bit keeps one level for the whole period, and an idle line sends repeated 1 bits.
- R3: A 0 bit inverts `line_out` one more time, BIT_CYCLES-HALF_CYCLES clocks after its boundary. The second level then lasts HALF_CYCLES clocks.
- R4: A character is sent as a 0 start bit, then data bits 0 through 7 in that order, then a 1 stop bit.
- R5: A byte is accepted at a clock edge where `data_ready` is 1 and `busy_out` is 0, and `busy_out` is 1 from the next cycle on.
- R6: The start bit begins at the first bit boundary strictly after the accepting edge, which is 1 to BIT_CYCLES clocks after that edge.
- R7: `busy_out` falls on the same edge where the stop bit ends. `data_ready` has no effect while `busy_out` is 1.
- R8: `nrz_out` equals the logical value of the current bit, changes only at bit boundaries, and is 1 while no character is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_in | input | DATA_W | Byte to send |
| data_ready | input | 1 | Byte offered by the sender |
| busy_out | output | 1 | Character pending or in flight |
| line_out | output | 1 | Biphase-mark coded line |
| nrz_out | output | 1 | NRZ copy of the framed character |

## Verification
Assertions check the following on every cycle:
- The line keeps its level except at a bit boundary or at the midpoint of a 0 bit.
- The line inverts at every boundary and at each 0-bit midpoint.
- The NRZ copy stays steady within a bit and reads 1 when idle.
- Busy rises only after an offered byte and falls only at a boundary.

Other behaviours show only in the bench's scenarios. It measures each pulse width to decode the line. It rebuilds characters to compare bit order and byte content. It checks the delay from acceptance to the start bit. It also checks that a byte offered while busy never appears on the line, and that a reset in mid-character recovers cleanly.

// File: rtl/bpe_pkg.sv
package bpe_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PEND = 2'd1,
        PH_SEND = 2'd2
    } phase_e;
endpackage

// File: rtl/bpe_timer.sv
module bpe_timer #(
    parameter int BIT_CYCLES  = 666,
    parameter int HALF_CYCLES = BIT_CYCLES / 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic bit_end,
    output logic mid_pt
);
    localparam int CW = $clog2(BIT_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);
    localparam logic [CW-1:0] MID  = CW'(HALF_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tm_s;

    tm_s tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (tm_q.cnt == '0) tm_d.cnt = LAST;
        else                tm_d.cnt = tm_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '{cnt: LAST};
        else        tm_q <= tm_d;
    end

    assign bit_end = (tm_q.cnt == '0);
    assign mid_pt  = (tm_q.cnt == MID);

    // R2: a boundary is followed by a full period, never by another boundary
    p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |=> (tm_q.cnt == LAST));
    p_single_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |=> !bit_end);
endmodule

// File: rtl/bpe_framer.sv
module bpe_framer
    import bpe_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_end,
    input  logic [DATA_W-1:0] data_in,
    input  logic              data_ready,
    output logic              busy,
    output logic              cur_bit
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int IW      = $clog2(FRAME_W);
    localparam logic [IW-1:0] LEFT_INIT = IW'(FRAME_W - 1);

    typedef struct packed {
        phase_e             ph;
        logic [FRAME_W-1:0] sh;
        logic [IW-1:0]      left;
        logic               cur;
    } fr_s;

    fr_s fr_d, fr_q;

    always_comb begin
        fr_d = fr_q;
        unique case (fr_q.ph)
            PH_IDLE: begin
                if (data_ready) begin
                    fr_d.sh = {1'b1, data_in, 1'b0};
                    fr_d.ph = PH_PEND;
                end
            end
            PH_PEND: begin
                if (bit_end) begin
                    fr_d.cur  = fr_q.sh[0];
                    fr_d.sh   = fr_q.sh >> 1;
                    fr_d.left = LEFT_INIT;
                    fr_d.ph   = PH_SEND;
                end
            end
            PH_SEND: begin
                if (bit_end) begin
                    if (fr_q.left != '0) begin
                        fr_d.cur  = fr_q.sh[0];
                        fr_d.sh   = fr_q.sh >> 1;
                        fr_d.left = fr_q.left - 1'b1;
                    end else begin
                        fr_d.cur = 1'b1;
                        fr_d.ph  = PH_IDLE;
                    end
                end
            end
            default: fr_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '{ph: PH_IDLE, sh: '1, left: '0, cur: 1'b1};
        else        fr_q <= fr_d;
    end

    assign busy    = (fr_q.ph != PH_IDLE);
    assign cur_bit = fr_q.cur;

    // R4: a pending character always opens with a 0 start bit
    p_start_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.ph == PH_PEND && bit_end) |=> (cur_bit == 1'b0));
    // R4: the last bit before returning to idle is the 1 stop bit
    p_stop_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.ph == PH_SEND && fr_q.left == '0) |-> (cur_bit == 1'b1));
endmodule

// File: rtl/bpe_line.sv
module bpe_line (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_end,
    input  logic mid_pt,
    input  logic cur_bit,
    output logic line_o
);
    typedef struct packed {
        logic line;
    } ln_s;

    ln_s ln_d, ln_q;
    logic flip;

    always_comb begin
        ln_d = ln_q;
        flip = bit_end | (mid_pt & ~cur_bit);
        if (flip) ln_d.line = ~ln_q.line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '{line: 1'b1};
        else        ln_q <= ln_d;
    end

    assign line_o = ln_q.line;

    // R2: every bit boundary inverts the line
    p_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |=> (line_o != $past(line_o)));
    // R3: a 0 bit inverts the line at its midpoint
    p_mid_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_pt && !cur_bit) |=> (line_o != $past(line_o)));
    // R2: a 1 bit keeps its level away from the boundary
    p_mark_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_end && cur_bit) |=> $stable(line_o));
endmodule

// File: rtl/bpe_encoder.sv
module bpe_encoder #(
    parameter int DATA_W      = 8,
    parameter int BIT_CYCLES  = 666,
    parameter int HALF_CYCLES = BIT_CYCLES / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic              data_ready,
    output logic              busy_out,
    output logic              line_out,
    output logic              nrz_out
);
    logic bit_end;
    logic mid_pt;
    logic cur_bit;

    bpe_timer #(
        .BIT_CYCLES (BIT_CYCLES),
        .HALF_CYCLES(HALF_CYCLES)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_end(bit_end),
        .mid_pt (mid_pt)
    );

    bpe_framer #(
        .DATA_W(DATA_W)
    ) i_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_end   (bit_end),
        .data_in   (data_in),
        .data_ready(data_ready),
        .busy      (busy_out),
        .cur_bit   (cur_bit)
    );

    bpe_line i_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_end(bit_end),
        .mid_pt (mid_pt),
        .cur_bit(cur_bit),
        .line_o (line_out)
    );

    assign nrz_out = cur_bit;

    // R5: busy only rises after a byte was offered
    p_busy_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_out) |-> $past(data_ready));
    // R7: busy only falls at a bit boundary
    p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_out) |-> $past(bit_end));
    // R8: the NRZ copy is steady inside a bit
    p_nrz_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_end |=> $stable(nrz_out));
    // R8: idle marking on the NRZ copy
    p_idle_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_out |-> nrz_out);
endmodule

// File: tb/test_bpe_encoder.sv
module test_bpe_encoder;
    localparam int CLK_NS   = 10;
    localparam int NBIT     = 21;
    localparam int NHALF    = 10;
    localparam int NFIRST   = NBIT - NHALF;
    localparam int WD_LIMIT = 100000;

    // {data, gap cycles, poke while busy}
    localparam int NVEC = 8;
    localparam logic [16:0] VEC [NVEC] = '{
        {8'h00, 8'd0,  1'b0},
        {8'hFF, 8'd3,  1'b1},
        {8'hA5, 8'd0,  1'b0},
        {8'h5A, 8'd40, 1'b1},
        {8'h01, 8'd1,  1'b0},
        {8'h80, 8'd0,  1'b0},
        {8'h3C, 8'd7,  1'b1},
        {8'hC3, 8'd0,  1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       data_ready = 1'b0;
    logic       busy_out, line_out, nrz_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [7:0] exp_b [32];
    int         acc_t [32];
    int         n_sent = 0;
    logic [7:0] rx_b  [32];
    int         rx_t  [32];
    int         rx_n = 0;

    bpe_encoder #(
        .DATA_W     (8),
        .BIT_CYCLES (NBIT),
        .HALF_CYCLES(NHALF)
    ) i_bpe_encoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_in   (data_in),
        .data_ready(data_ready),
        .busy_out  (busy_out),
        .line_out  (line_out),
        .nrz_out   (nrz_out)
    );

    always #(CLK_NS / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
        end
    endtask

    // line decoder: measures intervals between line inversions
    logic       prev_line = 1'b1;
    logic       prev_busy = 1'b0;
    bit         synced = 1'b0;
    bit         half = 1'b0;
    bit         in_char = 1'b0;
    int         last_t = 0;
    int         bit_t = 0;
    logic       bit_nrz = 1'b1;
    int         nb = 0;
    logic [7:0] sh = 8'h00;

    task automatic got_bit(input logic b);
        chk(bit_nrz == b, "R8 nrz copy", int'(bit_nrz), int'(b));
        if (!in_char) begin
            if (b == 1'b0) begin
                in_char = 1'b1;
                nb = 0;
                sh = 8'h00;
                if (rx_n < 32) rx_t[rx_n] = bit_t;
            end
        end else if (nb < 8) begin
            sh[nb] = b;
            nb++;
        end else begin
            chk(b == 1'b1, "R4 stop bit", int'(b), 1);
            if (rx_n < 32) rx_b[rx_n] = sh;
            rx_n++;
            in_char = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_line = line_out;
            prev_busy = busy_out;
            synced = 1'b0;
            half = 1'b0;
            in_char = 1'b0;
        end else begin
            if (prev_busy && !busy_out)
                chk(line_out != prev_line, "R7 busy falls at stop end", int'(line_out), int'(!prev_line));
            if (line_out != prev_line) begin
                if (!synced) begin
                    synced = 1'b1;
                    bit_t = cyc;
                    bit_nrz = nrz_out;
                end else if (half) begin
                    chk(cyc - last_t == NHALF, "R3 second half width", cyc - last_t, NHALF);
                    half = 1'b0;
                    got_bit(1'b0);
                    bit_t = cyc;
                    bit_nrz = nrz_out;
                end else if (cyc - last_t == NBIT) begin
                    got_bit(1'b1);
                    bit_t = cyc;
                    bit_nrz = nrz_out;
                end else begin
                    chk(cyc - last_t == NFIRST, "R2/R3 pulse width", cyc - last_t, NFIRST);
                    half = 1'b1;
                end
                last_t = cyc;
            end else if (synced) begin
                chk(cyc - last_t < NBIT, "R2 bit period", cyc - last_t, NBIT - 1);
            end
            prev_line = line_out;
            prev_busy = busy_out;
        end
    end

    task automatic send(input logic [7:0] b, input int gap, input bit poke);
        while (busy_out) @(negedge clk);
        chk(busy_out == 1'b0, "R5 idle before offer", int'(busy_out), 0);
        data_in = b;
        data_ready = 1'b1;
        @(negedge clk);
        acc_t[n_sent] = cyc;
        exp_b[n_sent] = b;
        n_sent++;
        chk(busy_out == 1'b1, "R5 busy next cycle", int'(busy_out), 1);
        data_ready = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            data_in = ~b;
            data_ready = 1'b1;
            @(negedge clk);
            data_ready = 1'b0;
            chk(busy_out == 1'b1, "R7 poke while busy", int'(busy_out), 1);
        end
        while (busy_out) @(negedge clk);
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(line_out == 1'b1, "R1 line reset", int'(line_out), 1);
        chk(nrz_out == 1'b1, "R1 nrz reset", int'(nrz_out), 1);
        chk(busy_out == 1'b0, "R1 busy reset", int'(busy_out), 0);
        rst_n = 1'b1;
        repeat (4 * NBIT) @(negedge clk);

        for (int i = 0; i < NVEC; i++)
            send(VEC[i][16:9], int'(VEC[i][8:1]), VEC[i][0]);
        repeat (3 * NBIT) @(negedge clk);

        // reset in the middle of a character, then recover
        data_in = 8'h96;
        data_ready = 1'b1;
        @(negedge clk);
        data_ready = 1'b0;
        repeat (5 * NBIT) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(line_out == 1'b1, "R1 line mid reset", int'(line_out), 1);
        chk(nrz_out == 1'b1, "R1 nrz mid reset", int'(nrz_out), 1);
        chk(busy_out == 1'b0, "R1 busy mid reset", int'(busy_out), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2 * NBIT) @(negedge clk);
        send(8'h69, 0, 1'b0);
        repeat (3 * NBIT) @(negedge clk);

        chk(rx_n == n_sent, "R7 character count", rx_n, n_sent);
        for (int i = 0; i < n_sent && i < rx_n; i++) begin
            chk(rx_b[i] == exp_b[i], "R4 byte content", int'(rx_b[i]), int'(exp_b[i]));
            chk((rx_t[i] - acc_t[i] >= 1) && (rx_t[i] - acc_t[i] <= NBIT),
                "R6 start latency", rx_t[i] - acc_t[i], NBIT);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", WD_LIMIT, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule